// File: doc/BRIEF.md
# Training-Based Receive Word Framer

The framer sits behind a clock-and-data recovery stage and turns a recovered serial bit stream into 10-bit words. The far-end transmitter shares the receiver's frequency but not its phase, so the position of the word boundary inside the stream is unknown after power-up. During initialization the transmitter repeats two fixed training words, one after the other. The framer takes one bit per clock, keeps the last ten bits in a window, and tests candidate boundary positions until the window holds the training words in correct alternation.

A mismatch moves the candidate boundary on by one bit, and the next position is tested on the very next bit. Once four alternating training words have been found at one position, the framer locks and freezes that position. From then on it delivers every aligned word, one strobe per ten clocks, whatever the data. A relock pulse drops the lock and restarts the search from the current position.

Top module: `wfr_framer`

## Requirements
- R1: While reset is held, `locked` and `word_valid` are 0 and `word_out` is 0.
- R2: The two training words are 0x0AA and 0x355 as `word_out` values, with bit 0 being the earliest received bit. When the stream alternates between them, starting at any of the ten bit phases, the framer locks.
- R3: The framer locks only after four consecutive words at one boundary position that are all training words and alternate. A stream that repeats one training word, an all-zero stream, and bursts of three alternating words broken by another word never produce a lock.
- R4: While locked, `word_valid` pulses once every 10 clocks. `word_out` holds the ten bits that followed the locked boundary, with bit 0 received first.
- R5: Once locked, the framer stays locked and keeps the same boundary while arbitrary non-training data arrives, until relock is requested.
- R6: A `relock` pulse clears `locked` and suppresses `word_valid` from the next clock on. The search then restarts and locks again on a fresh training stream at a new phase.
- R7: `word_valid` is never asserted unless the framer was locked on the previous clock.
- R8: On a mismatch the candidate boundary advances by one bit, modulo 10, and the new candidate is tested on the next clock. A lock is therefore reached within 70 bits of the start of training.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Recovered serial data bit |
| relock | input | 1 | Pulse that drops the lock and restarts the boundary search |
| word_out | output | 10 | Aligned word, bit 0 the earliest received bit |
| word_valid | output | 1 | One-clock strobe marking a new aligned word |
| locked | output | 1 | High once the word boundary is confirmed |

## Verification
The assertions take for granted that every clock delivers exactly one new bit, with no gaps, and that `relock` is synchronous to `clk`. Given that, the ten-clock spacing of `word_valid`, the frozen boundary and the one-bit slip must hold. The stimulus changes `rx_bit` and `relock` only on falling edges and drives a bit on every cycle without pause. Training words are sent exactly, so every check of lock time and word alignment rests on a gap-free stream. The framer is swept over all ten bit phases, with a run of zeros before each training burst so that no earlier data can complete a match.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

  // Search state of the framer
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } wfr_state_e;

endpackage

// File: rtl/wfr_window.sv
// Bit window plus boundary position tracker.
module wfr_window #(
  parameter int W    = 10,
  parameter int OFFW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  input  logic            slip_i,
  output logic [W-1:0]    win_o,
  output logic            edge_o,
  output logic [OFFW-1:0] off_o
);

  logic [W-1:0]    win_q, win_d;
  logic [OFFW-1:0] cnt_q, cnt_d;
  logic [OFFW-1:0] off_q, off_d;

  always_comb begin
    // Newest bit enters at the top, so the oldest ends in bit 0
    win_d = {bit_i, win_q[W-1:1]};
    cnt_d = (cnt_q == OFFW'(W-1)) ? '0 : cnt_q + 1'b1;
    off_d = off_q;
    if (slip_i) begin
      off_d = (off_q == OFFW'(W-1)) ? '0 : off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign win_o  = win_q;
  assign edge_o = (cnt_q == off_q);
  assign off_o  = off_q;

  // R8
  slip_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |-> edge_o);

  // R8
  slip_retest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |=> edge_o);

endmodule

// File: rtl/wfr_classify.sv
// Compares the window against both training words.
module wfr_classify #(
  parameter int           W     = 10,
  parameter logic [W-1:0] PAT_A = 10'h0AA,
  parameter logic [W-1:0] PAT_B = 10'h355
) (
  input  logic [W-1:0] win_i,
  output logic         hit_a_o,
  output logic         hit_b_o
);

  logic [W-1:0] eq_a;
  logic [W-1:0] eq_b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eq_a[i] = (win_i[i] == PAT_A[i]);
    assign eq_b[i] = (win_i[i] == PAT_B[i]);
  end

  assign hit_a_o = &eq_a;
  assign hit_b_o = &eq_b;

endmodule

// File: rtl/wfr_lock.sv
// Alternation counter and lock state.
module wfr_lock
  import wfr_pkg::*;
#(
  parameter int LOCKN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  input  logic relock_i,
  output logic slip_o,
  output logic locked_o
);

  localparam int CW = $clog2(LOCKN + 1);

  wfr_state_e    st_q, st_d;
  logic [CW-1:0] run_q, run_d;
  logic          prev_b_q, prev_b_d;
  logic          good;
  logic          slip;

  always_comb begin
    st_d     = st_q;
    run_d    = run_q;
    prev_b_d = prev_b_q;
    slip     = 1'b0;
    good     = (hit_a_i || hit_b_i) && ((run_q == '0) || (hit_b_i != prev_b_q));
    if (relock_i) begin
      st_d  = ST_HUNT;
      run_d = '0;
    end else if ((st_q == ST_HUNT) && edge_i) begin
      if (good) begin
        prev_b_d = hit_b_i;
        if (run_q == CW'(LOCKN - 1)) begin
          st_d  = ST_LOCK;
          run_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        slip  = 1'b1;
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HUNT;
      run_q    <= '0;
      prev_b_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      run_q    <= run_d;
      prev_b_q <= prev_b_d;
    end
  end

  assign slip_o   = slip;
  assign locked_o = (st_q == ST_LOCK);

  // R3
  lock_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(edge_i && (hit_a_i || hit_b_i)));

endmodule

// File: rtl/wfr_framer.sv
// Top level: reset release, datapath wiring and output register.
module wfr_framer #(
  parameter int           W     = 10,
  parameter int           LOCKN = 4,
  parameter logic [W-1:0] PAT_A = 10'h0AA,
  parameter logic [W-1:0] PAT_B = 10'h355
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit,
  input  logic         relock,
  output logic [W-1:0] word_out,
  output logic         word_valid,
  output logic         locked
);

  localparam int OFFW = (W > 1) ? $clog2(W) : 1;
  localparam int GW   = $clog2(W + 1);

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  logic [W-1:0]    win;
  logic            bnd;
  logic [OFFW-1:0] cand_off;
  logic            hit_a, hit_b;
  logic            slip;
  logic            lock_st;

  wfr_window #(.W(W), .OFFW(OFFW)) u_window (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .bit_i  (rx_bit),
    .slip_i (slip),
    .win_o  (win),
    .edge_o (bnd),
    .off_o  (cand_off)
  );

  wfr_classify #(.W(W), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_classify (
    .win_i   (win),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  wfr_lock #(.LOCKN(LOCKN)) u_lock (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .edge_i   (bnd),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .relock_i (relock),
    .slip_o   (slip),
    .locked_o (lock_st)
  );

  logic [W-1:0] wo_q, wo_d;
  logic         wv_q, wv_d;
  logic         wo_en;

  always_comb begin
    wv_d  = bnd && lock_st && !relock;
    wo_en = wv_d;
    wo_d  = win;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wo_q <= '0;
      wv_q <= 1'b0;
    end else begin
      wv_q <= wv_d;
      if (wo_en) begin
        wo_q <= wo_d;
      end
    end
  end

  assign word_out   = wo_q;
  assign word_valid = wv_q;
  assign locked     = lock_st;

  // Spacing monitor for the word strobe
  logic [GW-1:0] gap_q;
  logic          gap_arm_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gap_q     <= '0;
      gap_arm_q <= 1'b0;
    end else begin
      if (word_valid) begin
        gap_q <= '0;
      end else if (gap_q != GW'(W)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (word_valid) begin
        gap_arm_q <= 1'b1;
      end else if (!locked) begin
        gap_arm_q <= 1'b0;
      end
    end
  end

  // R4
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (word_valid && gap_arm_q) |-> (gap_q == GW'(W - 1)));

  // R5
  offset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (locked && !relock) |=> $stable(cand_off));

  // R6
  relock_drop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    relock |=> (!locked && !word_valid));

  // R7
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_valid |-> $past(locked));

endmodule

// File: tb/wfr_framer_test.sv
module wfr_framer_test;

  localparam int         W  = 10;
  localparam logic [9:0] PA = 10'h0AA;
  localparam logic [9:0] PB = 10'h355;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0;
  logic       relock = 1'b0;
  logic [9:0] word_out;
  logic       word_valid;
  logic       locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] seen [0:1023];
  int         n_seen = 0;
  int         lock_cycles = 0;
  int         drops = 0;
  logic       watch = 1'b0;

  always #4 clk = ~clk;

  wfr_framer #(.W(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .relock     (relock),
    .word_out   (word_out),
    .word_valid (word_valid),
    .locked     (locked)
  );

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (word_valid && n_seen < 1024) begin
      seen[n_seen] = word_out;
      n_seen = n_seen + 1;
    end
    if (locked) lock_cycles = lock_cycles + 1;
    if (watch && !locked) drops = drops + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic b);
    rx_bit = b;
    @(negedge clk);
  endtask

  task automatic put_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) put(w[i]);
  endtask

  function automatic logic [9:0] data_word(input int p, input int k);
    logic [9:0] v;
    v = 10'((p * 131 + k * 277 + 37) & 10'h3ff);
    if (v == PA || v == PB) v = v ^ 10'h001;
    return v;
  endfunction

  // Stream that must never lock: 0 same A, 1 same B, 2 zeros, 3 bursts of three
  task automatic no_lock_case(input int kind);
    int l0;
    int s0;
    logic [9:0] w;
    l0 = lock_cycles;
    s0 = n_seen;
    for (int i = 0; i < 60; i++) begin
      case (kind)
        0: w = PA;
        1: w = PB;
        2: w = 10'h000;
        default: w = (i % 4 == 3) ? 10'h000 : ((i % 4 == 1) ? PB : PA);
      endcase
      put_word(w);
    end
    chk($sformatf("R3 kind %0d lock cycles", kind), lock_cycles - l0, 0);
    chk($sformatf("R7 kind %0d strobes", kind), n_seen - s0, 0);
  endtask

  initial begin
    // R1: values under reset
    repeat (3) @(negedge clk);
    chk("R1 locked", {31'd0, locked}, 0);
    chk("R1 word_valid", {31'd0, word_valid}, 0);
    chk("R1 word_out", {22'd0, word_out}, 0);
    rst_n = 1'b1;
    repeat (4) put(1'b0);

    // R3, R7: streams that must not lock
    for (int kind = 0; kind < 4; kind++) no_lock_case(kind);

    // R2, R4, R5, R6, R8: sweep all bit phases
    for (int p = 0; p < 10; p++) begin
      int base;
      int d0;
      int idx;
      logic [9:0] dw [0:5];
      relock = 1'b1;
      put(1'b0);
      relock = 1'b0;
      chk($sformatf("R6 phase %0d locked after relock", p), {31'd0, locked}, 0);
      chk($sformatf("R6 phase %0d strobe after relock", p), {31'd0, word_valid}, 0);
      repeat (20) put(1'b0);
      repeat (p) put(1'b1);
      base = n_seen;
      for (int i = 0; i < 7; i++) put_word((i % 2 == 1) ? PB : PA);
      chk($sformatf("R2 R6 R8 phase %0d locked within 70 bits", p), {31'd0, locked}, 1);
      for (int i = 7; i < 34; i++) put_word((i % 2 == 1) ? PB : PA);
      watch = 1'b1;
      d0 = drops;
      for (int k = 0; k < 6; k++) begin
        dw[k] = data_word(p, k);
        put_word(dw[k]);
      end
      put_word(PA);
      put_word(PB);
      watch = 1'b0;
      chk($sformatf("R5 phase %0d lock held over data", p), drops - d0, 0);
      idx = base;
      while (idx < n_seen && (seen[idx] == PA || seen[idx] == PB)) idx++;
      for (int k = 0; k < 6; k++) begin
        logic [31:0] act;
        act = (idx + k < n_seen) ? {22'd0, seen[idx + k]} : 32'hffff_ffff;
        chk($sformatf("R4 R5 phase %0d data word %0d", p, k), act, {22'd0, dw[k]});
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule